// File: doc/BRIEF.md
# Flow-Through Burst SRAM Access Controller

This block is the synchronous front end of a single-port memory with a shared data bus. The memory itself is a small internal array. Address, control and byte-lane write selects are registered on the rising clock edge. The block decodes four operations: read, write, deselect and burst continue. An on-chip sequencer steps a burst through four addresses, in either linear or interleaved order. Write data follows its address by one clock. Because of that offset, a read may follow a write on the very next edge, and a write may follow a read the same way, with no idle cycle in between.

The bus is split at the pad boundary into three signals: an input half, an output half and a drive enable. An FPGA top level can join them into a real tristate pad. Reads are flow-through: the stored word leaves the array combinationally in the cycle after the address edge. An active-low clock enable freezes the whole block. Three chip selects, two active low and one active high, allow depth expansion. The output enable acts on the drive enable without waiting for a clock.

Top module: `fts_ctrl`

## Requirements
- R1: While `cke_n` is high, a rising edge changes nothing. Pending operations, the burst position, stored data, `dq_o` and `dq_oe` all keep their values.
- R2: An access starts only at an edge where `cke_n` is low, `advance` is low, `cs_a_n` is low, `cs_b` is high and `cs_c_n` is low. `we_n` low selects a write and `we_n` high selects a read.
- R3: For a write, `dq_i` and `lane_we_n` are sampled at the enabled edge after the one that took the address. A new access may be loaded on that same edge.
- R4: After a write address is taken, and until the next enabled edge, `dq_oe` stays 0 whatever `oe_n` is.
- R5: Lane i of the bus is `dq_i[9*i+8:9*i]`, and it is written only when `lane_we_n[i]` is 0. A lane whose select is 1 keeps its stored contents.
- R6: After a read is loaded, the addressed word appears on `dq_o` before the next edge. `dq_oe` is 1 exactly while `oe_n` is low, and it follows `oe_n` without a clock.
- R7: An enabled edge with `advance` low and any chip select inactive leaves the block idle, with `dq_oe` 0 from that edge on.
- R8: While `advance` is high at an enabled edge, the chip selects and `we_n` are ignored. An active burst keeps the direction it was loaded with, and an idle block stays idle.
- R9: Beat n (0 to 3) of a burst keeps the address bits above bit 1 from the load. With `il_mode`=0 its two low bits are (base+n) mod 4; with `il_mode`=1 they are base XOR n. A fifth beat wraps to the first.
- R10: A read loaded on the edge that completes a write to the same address returns the newly written data.
- R11: After synchronous reset (`rst` high at an edge) the block is idle and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cke_n | input | 1 | Clock enable, active low |
| advance | input | 1 | 1 = continue the burst, 0 = load a new access |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| we_n | input | 1 | 0 = write, 1 = read (sampled at load) |
| addr | input | 6 | Word address |
| lane_we_n | input | 4 | Per-lane write selects, active low |
| il_mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | 36 | Data bus, input half |
| dq_o | output | 36 | Data bus, output half |
| dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The first pattern is a write followed at once by a read of the same word. It separates correct one-cycle data-phase capture from capture on the wrong edge, and it shows whether the read sees the fresh data. Four-beat bursts are written at one base and read back from other bases, in both linear and interleaved order. This pattern separates the two address sequences and their wrap-around. During these bursts the chip selects and the write control are driven to inactive or opposite values, to show that they are ignored. The remaining patterns cover:
- partial-lane writes over a known word;
- clock-enable stalls, both during a read burst and during a write data phase;
- turning off each chip select in turn;
- toggling the output enable in mid-cycle.

Together these separate masking, freezing, deselect and asynchronous drive control.

// File: rtl/fts_pkg.sv
package fts_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/fts_burst_seq.sv
module fts_burst_seq #(
  parameter int AW    = 6,
  parameter int BURST = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          il_mode,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] addr
);
  localparam int CW = $clog2(BURST);

  logic [AW-1:0] base_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] low;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= base;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (il_mode) low = base_q[CW-1:0] ^ cnt_q;
    else         low = base_q[CW-1:0] + cnt_q;
  end

  assign addr = {base_q[AW-1:CW], low};

  // R9: counter wraps after the last beat
  p_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (step && !load && cnt_q == CW'(BURST-1)) |=> (cnt_q == '0));
  // R9: upper address bits stay fixed across a burst
  p_upper_r9: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (base_q == $past(base_q)));
endmodule

// File: rtl/fts_cmd.sv
module fts_cmd
  import fts_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cke_n,
  input  logic advance,
  input  logic sel_all,
  input  logic we_n,
  output op_e  op,
  output logic load,
  output logic step
);
  op_e op_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q <= OP_IDLE;
    end else if (!cke_n && !advance) begin
      if (sel_all) op_q <= we_n ? OP_RD : OP_WR;
      else         op_q <= OP_IDLE;
    end
  end

  assign op   = op_q;
  assign load = !cke_n && !advance && sel_all;
  assign step = !cke_n && advance && (op_q != OP_IDLE);

  // R1: a held edge keeps the pending operation
  p_hold_op_r1: assert property (@(posedge clk) disable iff (rst)
    cke_n |=> $stable(op_q));
  // R2: a qualified load always starts an access
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (op_q != OP_IDLE));
  // R8: advancing never changes direction
  p_dir_r8: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && advance) |=> (op_q == $past(op_q)));
endmodule

// File: rtl/fts_lane_ram.sv
module fts_lane_ram #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int DEPTH  = 64
) (
  input  logic                      clk,
  input  logic [LANES-1:0]          we,
  input  logic [$clog2(DEPTH)-1:0]  adr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) mem[adr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[adr];
  end
endmodule

// File: rtl/fts_ctrl.sv
module fts_ctrl
  import fts_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int DEPTH  = 64,
  parameter int BURST  = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cke_n,
  input  logic                            advance,
  input  logic                            cs_a_n,
  input  logic                            cs_b,
  input  logic                            cs_c_n,
  input  logic                            we_n,
  input  logic [$clog2(DEPTH)-1:0]        addr,
  input  logic [LANES-1:0]                lane_we_n,
  input  logic                            il_mode,
  input  logic                            oe_n,
  input  logic [LANES*LANE_W-1:0]         dq_i,
  output logic [LANES*LANE_W-1:0]         dq_o,
  output logic                            dq_oe
);
  localparam int AW = $clog2(DEPTH);

  logic          sel_all;
  op_e           op;
  logic          load;
  logic          step;
  logic [AW-1:0] cur_adr;
  logic [LANES-1:0] lane_we;

  assign sel_all = !cs_a_n && cs_b && !cs_c_n;

  fts_cmd u_cmd (
    .clk     (clk),
    .rst     (rst),
    .cke_n   (cke_n),
    .advance (advance),
    .sel_all (sel_all),
    .we_n    (we_n),
    .op      (op),
    .load    (load),
    .step    (step)
  );

  fts_burst_seq #(.AW(AW), .BURST(BURST)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .step    (step),
    .il_mode (il_mode),
    .base    (addr),
    .addr    (cur_adr)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_we
    assign lane_we[g] = (op == OP_WR) && !cke_n && !lane_we_n[g];
  end

  fts_lane_ram #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (lane_we),
    .adr   (cur_adr),
    .wdata (dq_i),
    .rdata (dq_o)
  );

  assign dq_oe = (op == OP_RD) && !oe_n;

  // R4: no drive during a write data phase
  p_wr_hiz_r4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_WR) |-> !dq_oe);
  // R7: a deselecting load releases the bus after the edge
  p_desel_hiz_r7: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !advance && !sel_all) |=> !dq_oe);
  // R1: a held edge leaves the output word unchanged
  p_hold_data_r1: assert property (@(posedge clk) disable iff (rst)
    cke_n |=> $stable(dq_o));
endmodule

// File: tb/fts_ctrl_tb_top.sv
module fts_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cke_n, advance, cs_a_n, cs_b, cs_c_n, we_n, il_mode, oe_n;
  logic [5:0]  addr;
  logic [3:0]  lane_we_n;
  logic [35:0] dq_i;
  logic [35:0] dq_o;
  logic        dq_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [35:0] exp_mem [64];

  always #5 clk = ~clk;

  fts_ctrl dut_i (
    .clk(clk), .rst(rst), .cke_n(cke_n), .advance(advance),
    .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n), .we_n(we_n),
    .addr(addr), .lane_we_n(lane_we_n), .il_mode(il_mode), .oe_n(oe_n),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  task automatic chk(input string tag, input logic [35:0] got, input logic [35:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic ld(input bit wr, input logic [5:0] a);
    cke_n = 0; advance = 0; cs_a_n = 0; cs_b = 1; cs_c_n = 0;
    we_n = !wr; addr = a;
  endtask

  task automatic adv(input bit wr_noise);
    cke_n = 0; advance = 1; cs_a_n = 1; cs_b = 0; cs_c_n = 1;
    we_n = wr_noise; addr = 6'h3F;
  endtask

  task automatic desel();
    cke_n = 0; advance = 0; cs_a_n = 0; cs_b = 0; cs_c_n = 0;
  endtask

  function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw,
                                        input logic [3:0] msk_n);
    logic [35:0] r = old;
    for (int i = 0; i < 4; i++) if (!msk_n[i]) r[9*i +: 9] = nw[9*i +: 9];
    return r;
  endfunction

  task automatic t_reset();
    chk("R11 dq_oe after reset", {35'd0, dq_oe}, 36'd0);
  endtask

  task automatic t_b2b();
    ld(1, 6'd5); step();
    chk("R4 dq_oe in write data phase", {35'd0, dq_oe}, 36'd0);
    dq_i = 36'hA_5A5A_5A5A; lane_we_n = 4'h0; exp_mem[5] = dq_i;
    ld(0, 6'd5); step();
    lane_we_n = 4'hF;
    chk("R3/R10 read right after write", dq_o, 36'hA_5A5A_5A5A);
    chk("R6 dq_oe during read", {35'd0, dq_oe}, 36'd1);
  endtask

  task automatic t_oe_async();
    oe_n = 1; #1;
    chk("R6 oe_n high releases bus", {35'd0, dq_oe}, 36'd0);
    oe_n = 0; #1;
    chk("R6 oe_n low drives bus", {35'd0, dq_oe}, 36'd1);
  endtask

  task automatic t_lanes();
    ld(1, 6'd9); step();
    dq_i = 36'h1_2345_6789; lane_we_n = 4'h0; exp_mem[9] = dq_i;
    ld(1, 6'd9); step();
    dq_i = 36'hF_EDCB_A987; lane_we_n = 4'b1010;
    exp_mem[9] = merge(exp_mem[9], dq_i, 4'b1010);
    ld(0, 6'd9); step();
    lane_we_n = 4'hF;
    chk("R5 masked lanes keep contents", dq_o, exp_mem[9]);
  endtask

  task automatic t_hold();
    ld(0, 6'd5); step();
    cke_n = 1; advance = 0; addr = 6'd9; we_n = 1; step();
    chk("R1 held load keeps data", dq_o, exp_mem[5]);
    cs_b = 0; step();
    chk("R1 held deselect keeps drive", {35'd0, dq_oe}, 36'd1);
    ld(1, 6'd12); step();
    cke_n = 1; dq_i = 36'h0_1111_1111; lane_we_n = 4'h0; step();
    cke_n = 0; advance = 1; dq_i = 36'h0_2222_2222; exp_mem[12] = dq_i;
    ld(0, 6'd12); step();
    lane_we_n = 4'hF;
    chk("R1 write phase held over stall", dq_o, 36'h0_2222_2222);
  endtask

  task automatic t_selects();
    for (int s = 0; s < 3; s++) begin
      ld(0, 6'd5); step();
      ld(0, 6'd5);
      if (s == 0) cs_a_n = 1;
      if (s == 1) cs_b = 0;
      if (s == 2) cs_c_n = 1;
      step();
      chk($sformatf("R2/R7 select %0d inactive", s), {35'd0, dq_oe}, 36'd0);
    end
    adv(0); cs_a_n = 0; cs_b = 1; cs_c_n = 0; step();
    chk("R8 advance while idle stays idle", {35'd0, dq_oe}, 36'd0);
  endtask

  task automatic t_burst_write();
    logic [35:0] w;
    il_mode = 0;
    ld(1, 6'd6); step();
    for (int i = 0; i < 4; i++) begin
      w = {4'h7, 28'h0, i[3:0]} ^ 36'h0_C0DE_0000;
      dq_i = w; lane_we_n = 4'h0;
      exp_mem[4 | ((2 + i) & 3)] = w;
      if (i < 3) adv(1); else desel();
      step();
    end
    lane_we_n = 4'hF;
    chk("R8 write burst released bus", {35'd0, dq_oe}, 36'd0);
  endtask

  task automatic t_burst_linear();
    il_mode = 0;
    ld(0, 6'd4); step();
    for (int i = 0; i < 5; i++) begin
      chk($sformatf("R9 linear beat %0d", i), dq_o, exp_mem[4 | ((4 + i) & 3)]);
      chk($sformatf("R8 read kept at beat %0d", i), {35'd0, dq_oe}, 36'd1);
      adv(0); step();
    end
  endtask

  task automatic t_burst_interleave();
    il_mode = 1;
    ld(0, 6'd7); step();
    for (int i = 0; i < 4; i++) begin
      chk($sformatf("R9 interleaved beat %0d", i), dq_o, exp_mem[4 | (3 ^ i)]);
      adv(0); step();
    end
    desel(); step();
    chk("R7 deselect after burst", {35'd0, dq_oe}, 36'd0);
    il_mode = 0;
  endtask

  initial begin
    rst = 1; cke_n = 0; advance = 0; cs_a_n = 1; cs_b = 0; cs_c_n = 1;
    we_n = 1; addr = '0; lane_we_n = 4'hF; il_mode = 0; oe_n = 0; dq_i = '0;
    repeat (3) step();
    rst = 0;
    t_reset();
    t_b2b();
    t_oe_async();
    t_lanes();
    t_hold();
    t_selects();
    t_burst_write();
    t_burst_linear();
    t_burst_interleave();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule